// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block turns a fast clock into a slow comparison pulse. The number of fast cycles between pulses is 64·N + A. A 64/65 prescaler stage is modelled inside the block as a synchronous down-counter. Two down-counters steer its modulus. The swallow count A keeps the prescaler at 65 for the first A prescaler periods of each division. The main count N sets how many prescaler periods make up one division. The remaining N − A periods run at 64.

The block samples the A and N inputs only at the boundary between two divisions. This means a host can change them at any moment without damaging the division in progress. The modulus-select line and the prescaler output tick are brought out beside the comparison pulse, so that a phase comparator or an external prescaler can follow the same timing.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low, fp and mod_sel are both low.
- R2: For legal settings (2 ≤ N, A < N), consecutive rising edges of fp are exactly 64·N + A clock cycles apart.
- R3: Within one division, mod_sel is high for exactly 65·A clock cycles. It rises only at a division boundary. With A = 0 it stays low.
- R4: fp is high for exactly one prescaler period per division, which is 64 cycles when A < N. It rises and falls only on a prescaler boundary.
- R5: pre_tick is a one-cycle pulse that occurs exactly N times per division.
- R6: A and N are captured only when a new division starts. A change made mid-division leaves that division's length unchanged, and the next division uses the new values.
- R7: After reset is released, the first rising clock edge starts a division. fp first goes high after edge 64·(N−1) + A + 1.
- R8: An N input of 0 or 1 is treated as N = 2.
- R9: The gap between pre_tick pulses is 65 cycles while mod_sel is high during that gap, and 64 cycles otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (VCO side) |
| rst_n | input | 1 | Active-low synchronous reset |
| swallow_in | input | 6 | Swallow count A, 0..63 |
| main_in | input | 12 | Main count N, legal 2..4095 |
| mod_sel | output | 1 | High selects divide-by-65 in the prescaler |
| pre_tick | output | 1 | One-cycle pulse at the end of each prescaler period |
| fp | output | 1 | Comparison pulse, one prescaler period wide per division |

## Verification
The hardest case to reach from the ports is a change of A and N in the middle of a running division. The bench locks onto a rising edge of fp and waits a fixed number of cycles inside the division. It then writes new values and measures both the division in progress and the one after it. The extreme swallow case (A = 63 with N = 64) is also exercised, so the modulus line holds 65 until the last period before fp.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int PRE_W  = 6,
  parameter int SWAL_W = 6,
  parameter int MAIN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SWAL_W-1:0] swallow_in,
  input  logic [MAIN_W-1:0] main_in,
  output logic              mod_sel,
  output logic              pre_tick,
  output logic              fp
);
  localparam int MOD_LO = 2 ** PRE_W;
  localparam int MOD_HI = MOD_LO + 1;
  localparam logic [PRE_W:0] LOAD_LO = (PRE_W+1)'(MOD_LO - 1);
  localparam logic [PRE_W:0] LOAD_HI = (PRE_W+1)'(MOD_HI - 1);
  localparam logic [MAIN_W-1:0] N_MIN = MAIN_W'(2);

  logic [PRE_W:0]    pre_q;
  logic [SWAL_W-1:0] a_q;
  logic [MAIN_W-1:0] n_q;
  logic              fp_q;

  wire tick   = (pre_q == '0);
  wire reload = (n_q <= MAIN_W'(1));

  wire [MAIN_W-1:0] n_load = (main_in < N_MIN) ? N_MIN : main_in;
  wire [SWAL_W-1:0] a_nxt  = reload ? swallow_in
                           : ((a_q != '0) ? a_q - SWAL_W'(1) : '0);
  wire [MAIN_W-1:0] n_nxt  = reload ? n_load : n_q - MAIN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      a_q   <= '0;
      n_q   <= '0;
      fp_q  <= 1'b0;
    end else if (tick) begin
      a_q   <= a_nxt;
      n_q   <= n_nxt;
      pre_q <= (a_nxt != '0) ? LOAD_HI : LOAD_LO;
      fp_q  <= (n_nxt == MAIN_W'(1));
    end else begin
      pre_q <= pre_q - (PRE_W+1)'(1);
    end
  end

  assign mod_sel  = (a_q != '0);
  assign pre_tick = tick & rst_n;
  assign fp       = fp_q;

  p_fp_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fp) |-> $past(tick));

  p_fp_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fp && tick) |=> !fp);

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(a_q) && $stable(n_q)));

  p_mod_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(tick && reload));

  p_pre_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LOAD_HI);

  p_main_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (n_q != '0));
endmodule

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  swallow_in = '0;
  logic [11:0] main_in = 12'd5;
  logic        mod_sel, pre_tick, fp;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst_n(rst_n), .swallow_in(swallow_in), .main_in(main_in),
    .mod_sel(mod_sel), .pre_tick(pre_tick), .fp(fp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic wait_fp_rise();
    logic last;
    last = fp;
    forever begin
      @(negedge clk);
      if (fp && !last) break;
      last = fp;
    end
  endtask

  task automatic measure(output int period, output int mod_cnt, output int fp_cnt,
                         output int ticks, output int gap_bad);
    logic last;
    int gap;
    period = 0; mod_cnt = 0; fp_cnt = 0; ticks = 0; gap_bad = 0;
    gap = 1;
    last = fp;
    forever begin
      if (mod_sel) mod_cnt++;
      if (fp) fp_cnt++;
      if (pre_tick) begin
        ticks++;
        if (gap != (mod_sel ? 65 : 64)) gap_bad++;
        gap = 0;
      end
      last = fp;
      @(negedge clk);
      period++;
      gap++;
      if (fp && !last) break;
    end
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 fp in reset", int'(fp), 0);
    chk("R1 mod_sel in reset", int'(mod_sel), 0);
  endtask

  task automatic t_first_r7(input int a, input int n);
    int k;
    swallow_in = 6'(a);
    main_in = 12'(n);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    while (!fp) begin
      @(negedge clk);
      k++;
    end
    chk("R7 first fp edge", k, 64 * (n - 1) + a + 1);
  endtask

  task automatic t_period(input int a, input int n);
    int p, m, f, t, g;
    swallow_in = 6'(a);
    main_in = 12'(n);
    wait_fp_rise();
    wait_fp_rise();
    measure(p, m, f, t, g);
    chk($sformatf("R2 period A=%0d N=%0d", a, n), p, 64 * n + a);
    chk($sformatf("R3 mod_sel cycles A=%0d", a), m, 65 * a);
    chk($sformatf("R4 fp width N=%0d", n), f, 64);
    chk($sformatf("R5 tick count N=%0d", n), t, n);
    chk("R9 prescaler gaps", g, 0);
  endtask

  task automatic t_switch_r6();
    int p, m, f, t, g;
    logic last;
    swallow_in = 6'd3;
    main_in = 12'd6;
    wait_fp_rise();
    wait_fp_rise();
    p = 0;
    last = fp;
    forever begin
      last = fp;
      @(negedge clk);
      p++;
      if (p == 100) begin
        swallow_in = 6'd1;
        main_in = 12'd8;
      end
      if (fp && !last) break;
    end
    chk("R6 division in progress keeps old ratio", p, 64 * 6 + 3);
    measure(p, m, f, t, g);
    chk("R6 next division uses new ratio", p, 64 * 8 + 1);
    chk("R6 new swallow count", m, 65);
  endtask

  task automatic t_clamp_r8();
    int p, m, f, t, g;
    swallow_in = 6'd0;
    main_in = 12'd1;
    wait_fp_rise();
    wait_fp_rise();
    measure(p, m, f, t, g);
    chk("R8 N=1 acts as 2", p, 128);
    main_in = 12'd0;
    wait_fp_rise();
    measure(p, m, f, t, g);
    chk("R8 N=0 acts as 2", p, 128);
    chk("R8 tick count", t, 2);
  endtask

  initial begin
    t_reset_r1();
    t_first_r7(2, 5);
    t_period(0, 5);
    t_period(4, 5);
    t_period(13, 20);
    t_period(9, 10);
    t_period(63, 64);
    t_switch_r6();
    t_clamp_r8();
    t_reset_r1();
    summary();
  end
endmodule